// File: doc/BRIEF.md
# BCD Clock-Calendar with Shadow Registers

This block keeps the time of day and the calendar date as packed BCD bytes, from hundredths of a second up to a two-digit year. A one-cycle pulse on `tick`, arriving at 100 Hz, advances an internal set of counters. A second set of registers, the user copy, is what the byte-wide register port returns. On every tick the whole user copy is reloaded from the advanced counters in one clock edge, so a reader never sees a half-carried value.

Software can clear a transfer-enable bit to freeze the user copy while reading several registers. The counters keep running underneath, and the next tick after the bit is set again brings the user copy up to date. The hours byte runs either as 00-23 or as 01-12 with a PM flag. Month lengths and leap Februaries are handled in hardware.

Top module: `bcd_timekeeper`

## Requirements
- R1: Hundredths (address 0x00) count 00-99, seconds (0x01) and minutes (0x02) count 00-59, all in packed BCD. A tick at 99 hundredths clears them and carries into seconds, and seconds carry into minutes in the same way.
- R2: When hours byte (0x04) bit 6 is 0, hours count 00-23. A tick at 23:59:59.99 gives 00:00:00.00 and advances the day of week (0x06, 01-07, with 07 followed by 01) and the date.
- R3: When hours bit 6 is 1, bits 4:0 hold 01-12 and bit 5 is PM. The step from 11 to 12 toggles PM, 12 is followed by 01, and the step from 11 PM to 12 AM advances the day and the date.
- R4: The date (0x08) wraps to 01 after 30 in April, June, September and November and after 31 in the other months except February. Month (0x09, 01-12) wraps from 12 to 01 and then advances the year (0x0A), and year 99 is followed by 00.
- R5: February ends on 29 when the BCD year is a multiple of four, including 00, and on 28 otherwise.
- R6: Command byte 0x0B bit 7 is the transfer enable, set after reset. While it is 0, ticks leave the user copy unchanged but the counters still advance. The first tick after it is set again loads the advanced counters.
- R7: A write to a time register sets both the counter and the user copy on the same edge, even when transfers are frozen.
- R8: Bits with no use read as 0 whatever is written: bit 7 of seconds, minutes and hours, bits 7:3 of day, bits 7:6 of date, bit 5 of month, and bits 6:0 of the command byte.
- R9: Month bits 7:6 are two plain control bits. They are stored as written and are kept unchanged when the month rolls over.
- R10: After reset the registers read as hundredths, seconds, minutes and hours 00 (24-hour mode), day 01, date 01, month 01, year 00 and command 0x80.
- R11: Any address other than 0x00, 0x01, 0x02, 0x04, 0x06, 0x08, 0x09, 0x0A and 0x0B reads 0, and writes to such an address have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle 100 Hz advance pulse |
| we | input | 1 | Register write strobe |
| addr | input | AW (6) | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational from the user copy |

## Verification
The hard cases are the carries that only occur at the end of a day, month or century, such as 23:59:59.99 on 31 December 99 or on 28 February of a leap year. Reaching them from reset would take millions of ticks. The stimulus therefore writes a seed value into every field, gives a single tick and reads all eight fields back, and a table of such seeds covers each month length, each leap-year class and each 12-hour transition. Freezing is exercised by clearing the transfer enable, writing a known hundredths value, ticking several times, and then checking that the first tick after re-enabling shows the hidden count.

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  localparam int NF = 8;

  logic [7:0] cnt [NF];
  logic [7:0] usr [NF];
  logic [7:0] inc [NF];
  logic       te;
  logic [1:0] ctl;
  logic [63:0] u_flat;

  function automatic logic [AW-1:0] fa(input int i);
    case (i)
      0: fa = AW'(0);
      1: fa = AW'(1);
      2: fa = AW'(2);
      3: fa = AW'(4);
      4: fa = AW'(6);
      5: fa = AW'(8);
      6: fa = AW'(9);
      default: fa = AW'(10);
    endcase
  endfunction

  function automatic logic [7:0] msk(input int i);
    case (i)
      1, 2, 3: msk = 8'h7F;
      4:       msk = 8'h07;
      5:       msk = 8'h3F;
      6:       msk = 8'h1F;
      default: msk = 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] rstv(input int i);
    rstv = (i >= 4 && i <= 6) ? 8'h01 : 8'h00;
  endfunction

  function automatic logic [7:0] binc(input logic [7:0] v);
    binc = (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  logic       hs_w, s_w, m_w, d_w, mo_w, leap, pm;
  logic [7:0] h, maxd;

  assign leap = cnt[7][4] ? (cnt[7][3:0] == 4'd2 || cnt[7][3:0] == 4'd6)
                          : (cnt[7][3:0] == 4'd0 || cnt[7][3:0] == 4'd4 || cnt[7][3:0] == 4'd8);

  always_comb begin
    case (cnt[6])
      8'h02:                      maxd = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: maxd = 8'h30;
      default:                    maxd = 8'h31;
    endcase
  end

  assign hs_w = cnt[0] == 8'h99;
  assign s_w  = hs_w && cnt[1] == 8'h59;
  assign m_w  = s_w && cnt[2] == 8'h59;
  assign mo_w = d_w && cnt[5] == maxd;

  always_comb begin
    for (int i = 0; i < NF; i++) inc[i] = cnt[i];
    h   = 8'h00;
    pm  = 1'b0;
    d_w = 1'b0;
    inc[0] = hs_w ? 8'h00 : binc(cnt[0]);
    if (hs_w) inc[1] = (cnt[1] == 8'h59) ? 8'h00 : binc(cnt[1]);
    if (s_w)  inc[2] = (cnt[2] == 8'h59) ? 8'h00 : binc(cnt[2]);
    if (m_w) begin
      if (cnt[3][6]) begin
        h  = {3'b000, cnt[3][4:0]};
        pm = cnt[3][5];
        if (h == 8'h12) h = 8'h01;
        else if (h == 8'h11) begin
          h   = 8'h12;
          d_w = pm;
          pm  = ~pm;
        end else h = binc(h);
        inc[3] = {2'b01, pm, h[4:0]};
      end else if (cnt[3] == 8'h23) begin
        inc[3] = 8'h00;
        d_w    = 1'b1;
      end else inc[3] = binc(cnt[3]);
    end
    if (d_w) begin
      inc[4] = (cnt[4] == 8'h07) ? 8'h01 : binc(cnt[4]);
      inc[5] = (cnt[5] == maxd) ? 8'h01 : binc(cnt[5]);
    end
    if (mo_w) begin
      inc[6] = (cnt[6] == 8'h12) ? 8'h01 : binc(cnt[6]);
      if (cnt[6] == 8'h12) inc[7] = (cnt[7] == 8'h99) ? 8'h00 : binc(cnt[7]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NF; i++) begin
        cnt[i] <= rstv(i);
        usr[i] <= rstv(i);
      end
      te  <= 1'b1;
      ctl <= 2'b00;
    end else begin
      for (int i = 0; i < NF; i++) begin
        if (we && addr == fa(i)) begin
          cnt[i] <= wdata & msk(i);
          usr[i] <= wdata & msk(i);
        end else begin
          if (tick)       cnt[i] <= inc[i];
          if (tick && te) usr[i] <= inc[i];
        end
      end
      if (we && addr == AW'(9))  ctl <= wdata[7:6];
      if (we && addr == AW'(11)) te  <= wdata[7];
    end
  end

  always_comb begin
    case (addr)
      AW'(0):  rdata = usr[0];
      AW'(1):  rdata = usr[1];
      AW'(2):  rdata = usr[2];
      AW'(4):  rdata = usr[3];
      AW'(6):  rdata = usr[4];
      AW'(8):  rdata = usr[5];
      AW'(9):  rdata = {ctl, 1'b0, usr[6][4:0]};
      AW'(10): rdata = usr[7];
      AW'(11): rdata = {te, 7'b0};
      default: rdata = 8'h00;
    endcase
  end

  assign u_flat = {usr[7], usr[6], usr[5], usr[4], usr[3], usr[2], usr[1], usr[0]};
endmodule

module bcd_timekeeper_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          we,
  input logic [AW-1:0] addr,
  input logic [7:0]    wdata,
  input logic [7:0]    rdata,
  input logic          te,
  input logic [63:0]   u_flat,
  input logic [7:0]    c_hs
);
  p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!te && !we) |=> $stable(u_flat));

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !we) |=> $stable(u_flat));

  p_wr_sec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == AW'(1)) |=> (u_flat[15:8] == ($past(wdata) & 8'h7F)));

  p_hs_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !we && c_hs == 8'h99) |=> (c_hs == 8'h00));

  p_day_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(6)) |-> (rdata[7:3] == 5'b0));

  p_blank_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (addr >= AW'(12) || addr == AW'(3) || addr == AW'(5) || addr == AW'(7)) |-> (rdata == 8'h00));
endmodule

bind bcd_timekeeper bcd_timekeeper_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .we(we), .addr(addr),
  .wdata(wdata), .rdata(rdata), .te(te), .u_flat(u_flat), .c_hs(cnt[0])
);

// File: tb/test_bcd_timekeeper.sv
module test_bcd_timekeeper;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       tick = 0;
  logic       we = 0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  bcd_timekeeper #(.AW(6)) i_bcd_timekeeper (
    .clk(clk), .rst_n(rst_n), .tick(tick), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  localparam logic [5:0] ADR [8] = '{6'h00, 6'h01, 6'h02, 6'h04, 6'h06, 6'h08, 6'h09, 6'h0A};

  // seed: hs sec min hr day date mon yr | expected after one tick
  localparam int NV = 16;
  localparam logic [127:0] VEC [NV] = '{
    128'h00000000_01010100_01000000_01010100, // R1
    128'h09591005_02150610_10591005_02150610, // R1
    128'h99591005_02150610_00001105_02150610, // R1
    128'h99595923_07311299_00000000_01010100, // R2 R4
    128'h99595923_03280223_00000000_04010323, // R5
    128'h99595923_03280224_00000000_04290224, // R5
    128'h99595923_03290224_00000000_04010324, // R5
    128'h99595923_03280200_00000000_04290200, // R5
    128'h99595923_03280226_00000000_04010326, // R5
    128'h99595923_03280212_00000000_04290212, // R5
    128'h99595923_03300405_00000000_04010505, // R4
    128'h99595923_03300619_00000000_04010719, // R4
    128'h99595923_03310105_00000000_04010205, // R4
    128'h99595951_03100305_00000072_03100305, // R3
    128'h99595971_03100305_00000052_04110305, // R3
    128'h99595972_03100305_00000061_03100305   // R3
  };
  localparam int VREQ [NV] = '{1, 1, 1, 2, 5, 5, 5, 5, 5, 5, 4, 4, 4, 3, 3, 3};

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic pulse();
    @(negedge clk);
    tick = 1;
    @(negedge clk);
    tick = 0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [7:0] exp, input string tag);
    addr = a;
    #1;
    check(tag, rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    for (int f = 0; f < 8; f++)
      rd(ADR[f], (f >= 4 && f <= 6) ? 8'h01 : 8'h00, "R10 reset");
    rd(6'h0B, 8'h80, "R10 command reset");

    for (int v = 0; v < NV; v++) begin
      for (int f = 0; f < 8; f++) wr(ADR[f], VEC[v][127-8*f -: 8]);
      pulse();
      for (int f = 0; f < 8; f++)
        rd(ADR[f], VEC[v][63-8*f -: 8], $sformatf("R%0d vector %0d field %0d", VREQ[v], v, f));
    end

    // R6 freeze with counters running
    wr(6'h0B, 8'h00);
    wr(6'h00, 8'h00);
    rd(6'h0B, 8'h00, "R6 enable cleared");
    repeat (5) pulse();
    rd(6'h00, 8'h00, "R6 frozen");
    // R7 write while frozen reaches user copy
    wr(6'h01, 8'h30);
    rd(6'h01, 8'h30, "R7 write while frozen");
    wr(6'h0B, 8'h80);
    rd(6'h00, 8'h00, "R6 no transfer before tick");
    pulse();
    rd(6'h00, 8'h06, "R6 resumed with hidden count");

    // R8 unused bits
    wr(6'h06, 8'hFF); rd(6'h06, 8'h07, "R8 day");
    wr(6'h08, 8'hFF); rd(6'h08, 8'h3F, "R8 date");
    wr(6'h01, 8'hFF); rd(6'h01, 8'h7F, "R8 seconds");
    wr(6'h02, 8'hFF); rd(6'h02, 8'h7F, "R8 minutes");
    wr(6'h04, 8'hFF); rd(6'h04, 8'h7F, "R8 hours");
    wr(6'h09, 8'h3F); rd(6'h09, 8'h1F, "R8 month");
    wr(6'h0B, 8'hFF); rd(6'h0B, 8'h80, "R8 command");

    // R9 month control bits through rollover
    wr(6'h00, 8'h99); wr(6'h01, 8'h59); wr(6'h02, 8'h59); wr(6'h04, 8'h23);
    wr(6'h06, 8'h01); wr(6'h08, 8'h31); wr(6'h09, 8'hC5); wr(6'h0A, 8'h05);
    rd(6'h09, 8'hC5, "R9 stored");
    pulse();
    rd(6'h09, 8'hC6, "R9 kept across rollover");
    rd(6'h08, 8'h01, "R4 May end");
    wr(6'h09, 8'h85); rd(6'h09, 8'h85, "R9 rewrite");

    // R11 unmapped addresses
    wr(6'h20, 8'h55); rd(6'h20, 8'h00, "R11 user area");
    wr(6'h03, 8'hAA); rd(6'h03, 8'h00, "R11 gap address");
    rd(6'h00, 8'h00, "R11 hundredths untouched");
    rd(6'h09, 8'h85, "R11 month untouched");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule